// File: doc/BRIEF.md
# Memory ECC Error Injection Unit

This unit sits between a memory controller and a 64-bit memory that stores eight extra check bits per word. On the write path it computes a single-error-correct, double-error-detect code over the data. While injection is armed, it can also invert chosen data bits under two 32-bit masks after the check bits have been formed. The memory therefore holds a word with a known, deliberate fault. On the read path it recomputes the code and corrects any single flipped bit in the returned data. A double flip is returned as read, with a flag raised.

Software sees the unit through a small 32-bit register file. There, error events are latched into status flags, and the first event is captured in detail: raw uncorrected data halves, check bits with syndrome, address and attributes. A counter with a threshold tracks correctable errors. A power-on test can flip one bit per pass, read the word back and confirm that the captured raw data XOR the written data reproduces the mask.

Top module: `secded_inject_unit`

## Requirements
- R1: After reset, registers 0 to 9 read zero. The counter register at offset 10 reads a count of 0 in bits [CNT_W-1:0] and a threshold of 1 in bits [16+CNT_W-1:16].
- R2: With injection off, the memory data equals the write data, even when the masks (offset 2 high half, offset 3 low half) are non-zero. Reading the stored word back returns it with rsp_sb and rsp_mb low.
- R3: While bit 0 of register 1 is set, each data bit set in the masks is inverted in mem_wdata. mem_wecc equals the check bits of the unmodified data.
- R4: Any single flipped bit among the 64 data and 8 check bits is corrected on rsp_data, with rsp_sb high and rsp_mb low.
- R5: Any two flipped bits give rsp_mb high and rsp_sb low, with rsp_data equal to the raw memory data.
- R6: Each corrected read increments the count, which saturates at 2^CNT_W-1. The single-error flag (status bit 0) is raised when the new count is at least the threshold.
- R7: On the first event while all status bits are clear, the capture registers load. These are the address (5), raw high half (6), raw low half (7), stored check bits in [7:0] and syndrome in [15:8] (8), and attributes (9).
- R8: An event while any status bit is set only sets the repeat flag (bit 2). All capture registers keep their contents.
- R9: Writing 1 to a status bit (offset 4) clears that bit only, and a write to any capture register clears it to zero.
- R10: While bit 0 of register 0 is set, checking is off. Reads return raw data, rsp_sb and rsp_mb stay low, and status, captures and count do not change.
- R11: A read with rd_sel_err high while checking is on sets the select flag (bit 3) and captures as in R7.
- R12: A write to offset 10 loads the count from bits [CNT_W-1:0] and the threshold from bits [16+CNT_W-1:16]. Other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| wr_valid | input | 1 | Write request from the controller |
| wr_data | input | 64 | Write data from the controller |
| mem_we | output | 1 | Write strobe to memory |
| mem_wdata | output | 64 | Data to memory, possibly corrupted |
| mem_wecc | output | 8 | Check bits to memory |
| rd_valid | input | 1 | Read data valid from memory |
| rd_addr | input | AW | Address of the read |
| rd_attr | input | ATTR_W | Attributes of the read |
| rd_sel_err | input | 1 | Memory select fault on the read |
| mem_rdata | input | 64 | Data from memory |
| mem_recc | input | 8 | Check bits from memory |
| rsp_data | output | 64 | Corrected read data to the requester |
| rsp_sb | output | 1 | Corrected single error on this read |
| rsp_mb | output | 1 | Uncorrectable error on this read |

## Verification
The bench builds the unit with AW=12, ATTR_W=4 and CNT_W=4. The narrow counter lets saturation and threshold crossing be reached in a few reads. The small address and attribute fields are still wide enough to tell captured transactions apart. The data path stays full width, so the bench injects through the masks at every one of the 64 data positions, flips each of the 8 check bits, and reads back all 2556 two-bit flip pairs over the 72-bit stored word.

// File: rtl/secded_inject_unit.sv
module secded_inject_unit #(
  parameter int AW     = 32,
  parameter int ATTR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              wr_valid,
  input  logic [63:0]       wr_data,
  output logic              mem_we,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_wecc,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_addr,
  input  logic [ATTR_W-1:0] rd_attr,
  input  logic              rd_sel_err,
  input  logic [63:0]       mem_rdata,
  input  logic [7:0]        mem_recc,
  output logic [63:0]       rsp_data,
  output logic              rsp_sb,
  output logic              rsp_mb
);

  localparam int NBIT = 64;

  function automatic logic [NBIT*7-1:0] build_pos();
    logic [NBIT*7-1:0] t;
    int k;
    t = '0;
    k = 0;
    for (int p = 3; p < 72; p++) begin
      if (((p & (p - 1)) != 0) && (k < NBIT)) begin
        t[k*7 +: 7] = 7'(p);
        k++;
      end
    end
    return t;
  endfunction

  localparam logic [NBIT*7-1:0] POS = build_pos();

  function automatic logic [6:0] ham(input logic [63:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 0; i < NBIT; i++)
      if (d[i]) c ^= POS[i*7 +: 7];
    return c;
  endfunction

  logic              check_off, inj_en;
  logic [31:0]       mask_hi, mask_lo;
  logic [3:0]        flags;
  logic [AW-1:0]     cap_addr;
  logic [31:0]       cap_hi, cap_lo;
  logic [15:0]       cap_ecc;
  logic [ATTR_W-1:0] cap_attr;
  logic [CNT_W-1:0]  sbe_cnt, sbe_thr;

  logic [6:0] wr_h;
  assign wr_h      = ham(wr_data);
  assign mem_wecc  = {^wr_data ^ ^wr_h, wr_h};
  assign mem_wdata = wr_data ^ (inj_en ? {mask_hi, mask_lo} : 64'h0);
  assign mem_we    = wr_valid;

  logic [6:0]  syn;
  logic        par;
  logic [63:0] fix;
  assign syn = ham(mem_rdata) ^ mem_recc[6:0];
  assign par = ^mem_rdata ^ ^mem_recc;

  always_comb
    for (int i = 0; i < NBIT; i++)
      fix[i] = (syn == POS[i*7 +: 7]);

  logic data_hit, corr, unc, chk_on;
  assign data_hit = |fix;
  assign corr     = par && (data_hit || $onehot0(syn));
  assign unc      = (!par && syn != 7'd0) || (par && !data_hit && !$onehot0(syn));
  assign chk_on   = !check_off;
  assign rsp_sb   = rd_valid && chk_on && corr;
  assign rsp_mb   = rd_valid && chk_on && unc;
  assign rsp_data = rsp_sb ? (mem_rdata ^ fix) : mem_rdata;

  logic [CNT_W-1:0] cnt_inc;
  logic sbe_hit, sel_hit, any_hit, fresh;
  assign cnt_inc = (&sbe_cnt) ? sbe_cnt : sbe_cnt + 1'b1;
  assign sbe_hit = rsp_sb && (cnt_inc >= sbe_thr);
  assign sel_hit = rd_valid && chk_on && rd_sel_err;
  assign any_hit = sbe_hit || rsp_mb || sel_hit;
  assign fresh   = (flags == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      check_off <= 1'b0;
      inj_en    <= 1'b0;
      mask_hi   <= '0;
      mask_lo   <= '0;
      flags     <= '0;
      cap_addr  <= '0;
      cap_hi    <= '0;
      cap_lo    <= '0;
      cap_ecc   <= '0;
      cap_attr  <= '0;
      sbe_cnt   <= '0;
      sbe_thr   <= CNT_W'(1);
    end else begin
      if (reg_we) begin
        case (reg_addr)
          4'd0:  check_off <= reg_wdata[0];
          4'd1:  inj_en    <= reg_wdata[0];
          4'd2:  mask_hi   <= reg_wdata;
          4'd3:  mask_lo   <= reg_wdata;
          4'd4:  flags     <= flags & ~reg_wdata[3:0];
          4'd5:  cap_addr  <= '0;
          4'd6:  cap_hi    <= '0;
          4'd7:  cap_lo    <= '0;
          4'd8:  cap_ecc   <= '0;
          4'd9:  cap_attr  <= '0;
          4'd10: begin
            sbe_cnt <= reg_wdata[CNT_W-1:0];
            sbe_thr <= reg_wdata[16 +: CNT_W];
          end
          default: ;
        endcase
      end
      if (rsp_sb) sbe_cnt <= cnt_inc;
      if (any_hit) begin
        if (fresh) begin
          flags    <= {sel_hit, 1'b0, rsp_mb, sbe_hit};
          cap_addr <= rd_addr;
          cap_hi   <= mem_rdata[63:32];
          cap_lo   <= mem_rdata[31:0];
          cap_ecc  <= {par, syn, mem_recc};
          cap_attr <= rd_attr;
        end else begin
          flags[2] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0:  reg_rdata[0] = check_off;
      4'd1:  reg_rdata[0] = inj_en;
      4'd2:  reg_rdata = mask_hi;
      4'd3:  reg_rdata = mask_lo;
      4'd4:  reg_rdata[3:0] = flags;
      4'd5:  reg_rdata = 32'(cap_addr);
      4'd6:  reg_rdata = cap_hi;
      4'd7:  reg_rdata = cap_lo;
      4'd8:  reg_rdata[15:0] = cap_ecc;
      4'd9:  reg_rdata = 32'(cap_attr);
      4'd10: begin
        reg_rdata[CNT_W-1:0]  = sbe_cnt;
        reg_rdata[16 +: CNT_W] = sbe_thr;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/secded_inject_unit_chk.sv
module secded_inject_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             rd_valid,
  input logic             check_off,
  input logic             rsp_sb,
  input logic             rsp_mb,
  input logic [3:0]       flags,
  input logic [31:0]      cap_hi,
  input logic [CNT_W-1:0] sbe_cnt
);

  p_sb_mb_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_sb && rsp_mb));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && check_off) |-> (!rsp_sb && !rsp_mb));

  p_mme_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> ($past(flags) != 4'd0));

  p_cap_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != 4'd0 && !reg_we) |=> $stable(cap_hi));

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&sbe_cnt) && !reg_we) |=> (&sbe_cnt));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !reg_we) |=> flags[0]);

endmodule

bind secded_inject_unit secded_inject_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .rd_valid(rd_valid),
  .check_off(check_off), .rsp_sb(rsp_sb), .rsp_mb(rsp_mb),
  .flags(flags), .cap_hi(cap_hi), .sbe_cnt(sbe_cnt)
);

// File: tb/sim_secded_inject_unit.sv
`timescale 1ns/1ps
module sim_secded_inject_unit;
  localparam int AW = 12, ATW = 4, CW = 4;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [3:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic wr_valid = 0; logic [63:0] wr_data = 0;
  logic mem_we; logic [63:0] mem_wdata; logic [7:0] mem_wecc;
  logic rd_valid = 0; logic [AW-1:0] rd_addr = 0; logic [ATW-1:0] rd_attr = 0;
  logic rd_sel_err = 0; logic [63:0] mem_rdata = 0; logic [7:0] mem_recc = 0;
  logic [63:0] rsp_data; logic rsp_sb, rsp_mb;

  always #5 clk = ~clk;

  secded_inject_unit #(.AW(AW), .ATTR_W(ATW), .CNT_W(CW)) u0 (.*);

  int tests = 0, fails = 0;
  bit done = 0;
  logic [71:0] mem [16];
  logic [63:0] last_wd, o_data;
  logic o_sb, o_mb;
  logic [31:0] rv, mh, ml;
  logic [63:0] pat;
  logic [7:0] ref_ecc [2];
  localparam logic [63:0] PA = 64'hFEDCBA9876543210;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d, input int slot);
    @(negedge clk); wr_valid = 1; wr_data = d;
    #1; mem[slot] = {mem_wecc, mem_wdata}; last_wd = mem_wdata;
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic rd(input int slot, input logic [71:0] flip, input logic [AW-1:0] a,
                    input logic [ATW-1:0] at, input logic se);
    @(negedge clk); rd_valid = 1; {mem_recc, mem_rdata} = mem[slot] ^ flip;
    rd_addr = a; rd_attr = at; rd_sel_err = se;
    #1; o_data = rsp_data; o_sb = rsp_sb; o_mb = rsp_mb;
    @(posedge clk); #1 rd_valid = 0; rd_sel_err = 0;
  endtask

  task automatic rw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rr(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired before the run completed");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rr(4'(a), rv); chk($sformatf("R1 reg %0d", a), 64'(rv), 0);
    end
    rr(10, rv); chk("R1 counter reg", 64'(rv), 64'h0001_0000);

    // R2 clean round trips with non-zero masks but injection off
    rw(2, 32'hFFFF_0000); rw(3, 32'h0000_FFFF);
    for (int n = 0; n < 70; n++) begin
      case (n)
        0: pat = 64'h0;  1: pat = '1;  2: pat = PA;  3: pat = ~PA;
        4: pat = 64'hAAAA_AAAA_5555_5555;  5: pat = 64'h0123_4567_89AB_CDEF;
        default: pat = 64'h1 << (n - 6);
      endcase
      wr(pat, 4);
      chk("R2 memory data unmodified", last_wd, pat);
      rd(4, 0, 0, 0, 0);
      chk("R2 read data", o_data, pat);
      chk("R2 no error flags", {o_sb, o_mb}, 0);
    end
    rr(4, rv); chk("R2 status quiet", 64'(rv), 0);

    wr(~PA, 2); ref_ecc[0] = mem[2][71:64];
    wr(PA, 3);  ref_ecc[1] = mem[3][71:64];

    // R3 R4 R6 R7: injection sweep over all 64 data bits
    for (int i = 0; i < 64; i++) begin
      pat = (i % 2) ? PA : ~PA;
      mh = (i >= 32) ? (32'h1 << (i - 32)) : 32'h0;
      ml = (i < 32) ? (32'h1 << i) : 32'h0;
      rw(4, 32'hF); rw(10, 32'h0001_0000);
      rw(2, mh); rw(3, ml); rw(1, 1);
      wr(pat, 1);
      rw(1, 0);
      chk($sformatf("R3 corrupted data bit %0d", i), last_wd ^ pat, {mh, ml});
      chk($sformatf("R3 check bits bit %0d", i), 64'(mem[1][71:64]), 64'(ref_ecc[i % 2]));
      rd(1, 0, AW'(i), ATW'(i), 0);
      chk($sformatf("R4 corrected bit %0d", i), o_data, pat);
      chk($sformatf("R4 flags bit %0d", i), {o_sb, o_mb}, 2'b10);
      rr(4, rv);  chk($sformatf("R6 single flag bit %0d", i), 64'(rv), 1);
      rr(10, rv); chk($sformatf("R6 count bit %0d", i), 64'(rv), 64'h0001_0001);
      rr(6, rv);  chk($sformatf("R7 raw high bit %0d", i), 64'(rv ^ pat[63:32]), 64'(mh));
      rr(7, rv);  chk($sformatf("R7 raw low bit %0d", i), 64'(rv ^ pat[31:0]), 64'(ml));
      rr(5, rv);  chk($sformatf("R7 address bit %0d", i), 64'(rv), 64'(i));
      rr(9, rv);  chk($sformatf("R7 attr bit %0d", i), 64'(rv), 64'(i % 16));
      rr(8, rv);  chk($sformatf("R7 check bits bit %0d", i), 64'(rv[7:0]), 64'(mem[1][71:64]));
    end

    // R4 check-bit flips
    for (int k = 0; k < 8; k++) begin
      rd(2, 72'h1 << (64 + k), 0, 0, 0);
      chk($sformatf("R4 check bit %0d data", k), o_data, ~PA);
      chk($sformatf("R4 check bit %0d flags", k), {o_sb, o_mb}, 2'b10);
    end

    // R5 all double flips; R8 status afterwards
    rw(4, 32'hF);
    for (int i = 0; i < 72; i++)
      for (int j = i + 1; j < 72; j++) begin
        rd(2, (72'h1 << i) | (72'h1 << j), 0, 0, 0);
        chk($sformatf("R5 pair %0d,%0d flags", i, j), {o_sb, o_mb}, 2'b01);
        chk($sformatf("R5 pair %0d,%0d data", i, j), o_data,
            ~PA ^ (64'(72'h1 << i) | 64'(72'h1 << j)));
      end
    rr(4, rv); chk("R8 double then repeat flags", 64'(rv), 4'b0110);

    // R8 repeat event keeps captures
    rw(4, 32'hF); rw(10, 32'h0001_0000);
    rw(2, 0); rw(3, 32'h20); rw(1, 1); wr(PA, 5); rw(1, 0);
    rd(5, 0, 12'h0A5, 4'd3, 0);
    rd(2, 72'h3, 12'h777, 4'd9, 0);
    rr(4, rv); chk("R8 flags after repeat", 64'(rv), 4'b0101);
    rr(5, rv); chk("R8 address kept", 64'(rv), 64'h0A5);
    rr(9, rv); chk("R8 attr kept", 64'(rv), 3);
    rr(7, rv); chk("R8 raw low kept", 64'(rv ^ PA[31:0]), 64'h20);

    // R9 write-one-to-clear and capture clearing
    rw(4, 32'h4); rr(4, rv); chk("R9 clear repeat only", 64'(rv), 1);
    rw(4, 32'h1); rr(4, rv); chk("R9 clear single", 64'(rv), 0);
    rw(5, 0); rr(5, rv); chk("R9 address cleared", 64'(rv), 0);
    rw(6, 32'h1234); rr(6, rv); chk("R9 raw high cleared", 64'(rv), 0);

    // R11 select fault
    rw(7, 0); rw(8, 0); rw(9, 0);
    rd(4, 0, 12'h123, 4'd6, 1);
    chk("R11 no data error", {o_sb, o_mb}, 0);
    rr(4, rv); chk("R11 select flag", 64'(rv), 4'b1000);
    rr(5, rv); chk("R11 address", 64'(rv), 64'h123);
    rr(9, rv); chk("R11 attr", 64'(rv), 6);

    // R10 checking disabled
    rw(4, 32'hF); rw(5, 0); rw(10, 32'h0001_0000); rw(0, 1);
    rd(2, 72'h3, 12'h44, 4'd1, 0);
    chk("R10 double raw data", o_data, ~PA ^ 64'h3);
    chk("R10 double no flags", {o_sb, o_mb}, 0);
    rd(2, 72'h10, 12'h45, 4'd1, 1);
    chk("R10 single not corrected", o_data, ~PA ^ 64'h10);
    chk("R10 single no flags", {o_sb, o_mb}, 0);
    rr(4, rv);  chk("R10 status unchanged", 64'(rv), 0);
    rr(5, rv);  chk("R10 no capture", 64'(rv), 0);
    rr(10, rv); chk("R10 count unchanged", 64'(rv), 64'h0001_0000);
    rw(0, 0);

    // R6 threshold crossing
    rw(4, 32'hF); rw(10, 32'h0003_0000);
    rd(2, 72'h80, 0, 0, 0); rd(2, 72'h80, 0, 0, 0);
    rr(4, rv);  chk("R6 below threshold no flag", 64'(rv), 0);
    rr(10, rv); chk("R6 count two", 64'(rv), 64'h0003_0002);
    rd(2, 72'h80, 0, 0, 0);
    rr(4, rv);  chk("R6 at threshold flag", 64'(rv), 1);
    rr(10, rv); chk("R6 count three", 64'(rv), 64'h0003_0003);

    // R6 saturation
    rw(4, 32'hF); rw(10, 32'h000F_000E);
    rd(2, 72'h100, 0, 0, 0);
    rr(10, rv); chk("R6 count reaches max", 64'(rv), 64'h000F_000F);
    rd(2, 72'h100, 0, 0, 0);
    rr(10, rv); chk("R6 count saturated", 64'(rv), 64'h000F_000F);
    rr(4, rv);  chk("R6 flags at saturation", 64'(rv), 4'b0101);

    // R12 counter register write
    rw(10, 32'h000A_0005); rr(10, rv); chk("R12 fields loaded", 64'(rv), 64'h000A_0005);
    rw(10, 32'hFFFF_FFFF); rr(10, rv); chk("R12 other bits ignored", 64'(rv), 64'h000F_000F);

    summary();
    $finish;
  end
endmodule